// File: doc/BRIEF.md
# Shadow-Memory Read Checker

This block sits next to a synchronous single-write-port, single-read-port memory controller. It observes the controller's request pins and its response pins without driving anything back. It keeps a private copy of the memory contents. Each write that the controller takes updates that copy. When a response arrives, the block compares the returned word with the word the copy held for the requested address at the moment of the request.

Besides data integrity, the block polices the handshake:

- the response valid must follow a read request by exactly one cycle;
- read data must not move while no read is outstanding;
- a write and a read in the same cycle must not target the same word;
- addresses must lie inside the configured depth;
- the write and read strobes must only be raised while the chip enable is high.

Each error category owns a sticky flag and a saturating counter. Three statistics counters and a single pass bit summarise the run. The block is meant to be instantiated in a simulation top or in an on-chip self-test wrapper, alongside the controller it watches.

Top module: `mem_shadow_monitor`

## Requirements
- R1: After reset every word of the copy reads as zero. A cycle with chip enable, write strobe and an address below DEPTH stores the write data into the copy at the following clock edge.
- R2: In a cycle with chip enable and read strobe, the expected word is taken from the copy before that same cycle's write is applied. If the response carries valid with a different word, it counts as a data mismatch in category 0.
- R3: `wr_total` counts accepted in-range writes. `rd_total` counts responses whose valid follows a read request. `match_total` counts those responses whose data equals the expected word. `match_total` never exceeds `rd_total`, and no statistic ever decreases.
- R4: A cycle where response valid disagrees with whether a read was sampled in the previous cycle is a latency error in category 1. This covers both an orphan valid and a missing valid.
- R5: When no read was sampled in the previous cycle, any change of the read data from its previous cycle's value is a stability error in category 2.
- R6: Chip enable with both strobes high and equal write and read addresses is a conflict error in category 3. The write is still taken.
- R7: A write or read request with an address of DEPTH or more is a range error in category 4. Such a write leaves the copy unchanged. The response to such a read is counted in `rd_total` but never in `match_total`.
- R8: Either strobe high while chip enable is low is an enable error in category 5. It neither writes the copy nor starts a read.
- R9: A hit in category k sets bit k of `err_flags` one cycle later and raises the counter at `err_counts[k*ERR_W +: ERR_W]` by one. The counter saturates at 2**ERR_W-1. Flags and counters clear only on reset.
- R10: `pass` is high exactly when every error counter is zero and `match_total` equals `rd_total`.
- R11: During and right after reset all flags, counters and statistics are zero and `pass` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the watched controller |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_ce | input | 1 | Observed chip enable |
| mon_we | input | 1 | Observed write strobe |
| mon_waddr | input | ADDR_W | Observed write address |
| mon_wdata | input | DATA_W | Observed write data |
| mon_re | input | 1 | Observed read strobe |
| mon_raddr | input | ADDR_W | Observed read address |
| mon_rvalid | input | 1 | Observed response valid |
| mon_rdata | input | DATA_W | Observed response data |
| err_flags | output | 6 | Sticky flag per error category |
| err_counts | output | 6*ERR_W | Saturating counter per category, category k at k*ERR_W |
| wr_total | output | STAT_W | Accepted write count |
| rd_total | output | STAT_W | Response count |
| match_total | output | STAT_W | Matching response count |
| pass | output | 1 | High while the run is clean |

## Verification
The bench builds the block with DATA_W=8, ADDR_W=4, DEPTH=12 and ERR_W=4, with STAT_W left at 16. A depth below the address space leaves addresses 12 to 15 free, so range errors can be provoked on both paths. The four-bit error counters reach saturation after fifteen hits, so twenty enable violations in a row show the counter sticking at 15. Eight-bit data keeps the corrupted and pseudo-random words easy to tell apart in the reference model's per-cycle comparison.

// File: rtl/mss_pkg.sv
package mss_pkg;
    // error category indices; these bit positions are visible at the ports
    localparam int NCAT      = 6;
    localparam int CAT_DATA  = 0;
    localparam int CAT_LAT   = 1;
    localparam int CAT_STAB  = 2;
    localparam int CAT_CONF  = 3;
    localparam int CAT_RANGE = 4;
    localparam int CAT_EN    = 5;
endpackage

// File: rtl/mss_shadow.sv
module mss_shadow #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    // read returns the contents before this cycle's write (R2)
    always_comb begin
        mem_d   = mem_q;
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_en && wr_addr == ADDR_W'(i)) begin
                mem_d[i] = wr_data;
            end
            if (rd_addr == ADDR_W'(i)) begin
                rd_data = mem_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/mss_tally.sv
module mss_tally #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    output logic             flag,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic             flag;
        logic [CNT_W-1:0] cnt;
    } tally_t;

    tally_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (hit) begin
            t_d.flag = 1'b1;
            if (t_q.cnt != '1) begin
                t_d.cnt = t_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign flag  = t_q.flag;
    assign count = t_q.cnt;
endmodule

// File: rtl/mem_shadow_monitor.sv
module mem_shadow_monitor
    import mss_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 12,
    parameter int ERR_W  = 4,
    parameter int STAT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mon_ce,
    input  logic                    mon_we,
    input  logic [ADDR_W-1:0]       mon_waddr,
    input  logic [DATA_W-1:0]       mon_wdata,
    input  logic                    mon_re,
    input  logic [ADDR_W-1:0]       mon_raddr,
    input  logic                    mon_rvalid,
    input  logic [DATA_W-1:0]       mon_rdata,
    output logic [NCAT-1:0]         err_flags,
    output logic [NCAT*ERR_W-1:0]   err_counts,
    output logic [STAT_W-1:0]       wr_total,
    output logic [STAT_W-1:0]       rd_total,
    output logic [STAT_W-1:0]       match_total,
    output logic                    pass
);
    localparam logic [ADDR_W:0] DEPTH_X = (ADDR_W + 1)'(DEPTH);

    typedef struct packed {
        logic              rd_pend;
        logic              rd_chk;
        logic [DATA_W-1:0] exp_data;
        logic              prev_vld;
        logic [DATA_W-1:0] prev_data;
        logic [STAT_W-1:0] wr_cnt;
        logic [STAT_W-1:0] rd_cnt;
        logic [STAT_W-1:0] ok_cnt;
    } mon_t;

    mon_t s_d, s_q;

    logic              waddr_in, raddr_in, wr_ok, rd_req, rd_seen;
    logic [DATA_W-1:0] shadow_rd;
    logic [NCAT-1:0]   hit;

    assign waddr_in = {1'b0, mon_waddr} < DEPTH_X;
    assign raddr_in = {1'b0, mon_raddr} < DEPTH_X;
    assign wr_ok    = mon_ce & mon_we & waddr_in;
    assign rd_req   = mon_ce & mon_re;
    assign rd_seen  = mon_rvalid & s_q.rd_pend;

    mss_shadow #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok),
        .wr_addr (mon_waddr),
        .wr_data (mon_wdata),
        .rd_addr (mon_raddr),
        .rd_data (shadow_rd)
    );

    function automatic logic [STAT_W-1:0] bump(input logic [STAT_W-1:0] v, input logic en);
        return (en && v != '1) ? v + STAT_W'(1) : v;
    endfunction

    always_comb begin
        s_d = s_q;
        hit = '0;

        hit[CAT_EN]    = ~mon_ce & (mon_we | mon_re);
        hit[CAT_CONF]  = mon_ce & mon_we & mon_re & (mon_waddr == mon_raddr);
        hit[CAT_RANGE] = (mon_ce & mon_we & ~waddr_in) | (rd_req & ~raddr_in);
        hit[CAT_LAT]   = mon_rvalid ^ s_q.rd_pend;
        hit[CAT_STAB]  = s_q.prev_vld & ~s_q.rd_pend & (mon_rdata != s_q.prev_data);
        hit[CAT_DATA]  = rd_seen & s_q.rd_chk & (mon_rdata != s_q.exp_data);

        // one-stage expected-data pipeline aligned with the response
        s_d.rd_pend  = rd_req;
        s_d.rd_chk   = rd_req & raddr_in;
        s_d.exp_data = shadow_rd;

        s_d.prev_vld  = 1'b1;
        s_d.prev_data = mon_rdata;

        s_d.wr_cnt = bump(s_q.wr_cnt, wr_ok);
        s_d.rd_cnt = bump(s_q.rd_cnt, rd_seen);
        s_d.ok_cnt = bump(s_q.ok_cnt, rd_seen & s_q.rd_chk & (mon_rdata == s_q.exp_data));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar g = 0; g < NCAT; g++) begin : g_cat
        mss_tally #(.CNT_W(ERR_W)) u_tally (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit[g]),
            .flag  (err_flags[g]),
            .count (err_counts[g*ERR_W +: ERR_W])
        );
    end

    assign wr_total    = s_q.wr_cnt;
    assign rd_total    = s_q.rd_cnt;
    assign match_total = s_q.ok_cnt;
    assign pass        = (err_counts == '0) && (s_q.rd_cnt == s_q.ok_cnt);
endmodule

// File: rtl/mss_checker.sv
module mss_checker
    import mss_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 12,
    parameter int STAT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mon_ce,
    input logic              mon_we,
    input logic              mon_re,
    input logic [ADDR_W-1:0] mon_waddr,
    input logic [ADDR_W-1:0] mon_raddr,
    input logic              mon_rvalid,
    input logic [NCAT-1:0]   err_flags,
    input logic [STAT_W-1:0] rd_total,
    input logic [STAT_W-1:0] match_total,
    input logic              pass
);
    localparam logic [ADDR_W:0] DEPTH_X = (ADDR_W + 1)'(DEPTH);

    p_enable_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_ce && (mon_we || mon_re)) |=> err_flags[CAT_EN]);

    p_same_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_ce && mon_we && mon_re && mon_waddr == mon_raddr) |=> err_flags[CAT_CONF]);

    p_wr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_ce && mon_we && {1'b0, mon_waddr} >= DEPTH_X) |=> err_flags[CAT_RANGE]);

    p_orphan_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_rvalid && !$past(mon_ce && mon_re)) |=> err_flags[CAT_LAT]);

    p_flags_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(err_flags) & ~err_flags) == '0));

    p_match_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        match_total <= rd_total);

    p_reads_monotone_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rd_total >= $past(rd_total));

    p_pass_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> err_flags == '0);
endmodule

bind mem_shadow_monitor mss_checker #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH),
    .STAT_W (STAT_W)
) u_mss_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mon_ce      (mon_ce),
    .mon_we      (mon_we),
    .mon_re      (mon_re),
    .mon_waddr   (mon_waddr),
    .mon_raddr   (mon_raddr),
    .mon_rvalid  (mon_rvalid),
    .err_flags   (err_flags),
    .rd_total    (rd_total),
    .match_total (match_total),
    .pass        (pass)
);

// File: tb/mem_shadow_monitor_bench.sv
`timescale 1ns/1ps
module mem_shadow_monitor_bench;
    localparam int DW = 8, AW = 4, DEPTH = 12, EW = 4, SW = 16, NC = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          ce = 0, we = 0, re = 0, rv = 0;
    logic [AW-1:0] wa = 0, ra = 0;
    logic [DW-1:0] wd = 0, rd = 0;
    logic [NC-1:0]    err_flags;
    logic [NC*EW-1:0] err_counts;
    logic [SW-1:0]    wr_total, rd_total, match_total;
    logic             pass;

    mem_shadow_monitor #(.DATA_W(DW), .ADDR_W(AW), .DEPTH(DEPTH), .ERR_W(EW), .STAT_W(SW))
    u_mem_shadow_monitor (
        .clk(clk), .rst_n(rst_n), .mon_ce(ce), .mon_we(we), .mon_waddr(wa), .mon_wdata(wd),
        .mon_re(re), .mon_raddr(ra), .mon_rvalid(rv), .mon_rdata(rd),
        .err_flags(err_flags), .err_counts(err_counts), .wr_total(wr_total),
        .rd_total(rd_total), .match_total(match_total), .pass(pass)
    );

    int n_run = 0, n_fail = 0;
    bit live = 0;
    logic [DW-1:0] hold = 0;

    task automatic check(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // behavioural reference model, updated on the same edges as the design
    int m_sh[DEPTH];
    int m_cnt[NC];
    bit m_pend, m_chk, m_pv;
    int m_exp, m_prev, m_wr, m_rd, m_ok;
    bit h[NC];
    string ctag[NC] = '{"R2/R9 mismatch", "R4/R9 latency", "R5/R9 stability",
                        "R6/R9 conflict", "R7/R9 range", "R8/R9 enable"};

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_sh[i]) m_sh[i] = 0;
            foreach (m_cnt[i]) m_cnt[i] = 0;
            m_pend = 0; m_chk = 0; m_pv = 0; m_exp = 0; m_prev = 0;
            m_wr = 0; m_rd = 0; m_ok = 0;
        end else begin
            int a_w, a_r;
            a_w = int'(wa);
            a_r = int'(ra);
            h[5] = !ce && (we || re);
            h[3] = ce && we && re && (wa == ra);
            h[4] = (ce && we && a_w >= DEPTH) || (ce && re && a_r >= DEPTH);
            h[1] = (rv != m_pend);
            h[2] = m_pv && !m_pend && (int'(rd) != m_prev);
            h[0] = rv && m_pend && m_chk && (int'(rd) != m_exp);
            if (rv && m_pend) begin
                m_rd++;
                if (m_chk && int'(rd) == m_exp) m_ok++;
            end
            for (int k = 0; k < NC; k++) if (h[k] && m_cnt[k] < (1 << EW) - 1) m_cnt[k]++;
            m_pend = ce && re;
            m_chk  = m_pend && a_r < DEPTH;
            m_exp  = (a_r < DEPTH) ? m_sh[a_r] : 0;
            if (ce && we && a_w < DEPTH) begin
                m_sh[a_w] = int'(wd);
                m_wr++;
            end
            m_prev = int'(rd);
            m_pv   = 1;
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && live) begin
            bit clean;
            clean = (m_rd == m_ok);
            for (int k = 0; k < NC; k++) begin
                check(ctag[k], int'(err_flags[k]), int'(m_cnt[k] != 0));
                check(ctag[k], int'(err_counts[k*EW +: EW]), m_cnt[k]);
                if (m_cnt[k] != 0) clean = 0;
            end
            check("R1/R3 writes", int'(wr_total), m_wr);
            check("R3 reads", int'(rd_total), m_rd);
            check("R3 matched", int'(match_total), m_ok);
            check("R10 pass", int'(pass), int'(clean));
        end
    end

    task automatic step(bit c, bit w, int wad, int wdat, bit r, int rad, bit v, logic [DW-1:0] dat);
        ce = c; we = w; wa = AW'(wad); wd = DW'(wdat);
        re = r; ra = AW'(rad); rv = v; rd = dat; hold = dat;
        @(negedge clk);
    endtask

    function automatic int pat(int i);
        return (i * 37 + 11) & 255;
    endfunction

    function automatic int cnt(int k);
        return int'(err_counts[k*EW +: EW]);
    endfunction

    initial begin
        #(5.0 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int fr[DEPTH];
        int unsigned lf;
        bit pv;
        logic [DW-1:0] pval;
        repeat (3) @(negedge clk);
        // R11: state during reset
        check("R11 reset pass", int'(pass), 1);
        rst_n = 1'b1;
        live  = 1;
        check("R11 flags", int'(err_flags), 0);
        check("R11 counters", int'(err_counts), 0);
        check("R11 totals", int'(wr_total + rd_total + match_total), 0);
        check("R11 pass", int'(pass), 1);

        // R1: fill, then back-to-back readback
        for (int i = 0; i < DEPTH; i++) step(1, 1, i, pat(i), 0, 0, 0, hold);
        for (int i = 0; i < DEPTH; i++)
            step(1, 0, 0, 0, 1, i, i > 0, (i > 0) ? DW'(pat(i - 1)) : hold);
        step(1, 0, 0, 0, 0, 0, 1, DW'(pat(DEPTH - 1)));
        check("R3 write total", int'(wr_total), DEPTH);
        check("R3 read total", int'(rd_total), DEPTH);
        check("R3 match total", int'(match_total), DEPTH);
        check("R10 pass after clean traffic", int'(pass), 1);

        // R2/R6: same-cycle write and read of one word sees the old value
        step(1, 1, 4, 8'hC3, 1, 4, 0, hold);
        step(1, 0, 0, 0, 0, 0, 1, DW'(pat(4)));
        check("R6 conflict count", cnt(3), 1);
        check("R2 old value expected", cnt(0), 0);
        step(1, 0, 0, 0, 1, 4, 0, hold);
        step(1, 0, 0, 0, 0, 0, 1, 8'hC3);
        check("R1 shadow updated", cnt(0), 0);

        // R2: wrong data
        step(1, 0, 0, 0, 1, 5, 0, hold);
        step(1, 0, 0, 0, 0, 0, 1, DW'(pat(5) ^ 1));
        check("R2 mismatch count", cnt(0), 1);
        check("R10 pass low", int'(pass), 0);
        check("R3 matched lags", int'(rd_total - match_total), 1);

        // R4: orphan valid, then missing valid
        step(1, 0, 0, 0, 0, 0, 1, hold);
        check("R4 orphan valid", cnt(1), 1);
        step(1, 0, 0, 0, 1, 6, 0, hold);
        step(1, 0, 0, 0, 0, 0, 0, hold);
        check("R4 missing valid", cnt(1), 2);

        // R5: data moves while idle
        step(1, 0, 0, 0, 0, 0, 0, hold ^ 8'hFF);
        check("R5 stability", cnt(2), 1);
        step(1, 0, 0, 0, 0, 0, 0, hold);
        check("R5 steady idle", cnt(2), 1);

        // R7: out-of-range write and read
        step(1, 1, 13, 8'h77, 0, 0, 0, hold);
        check("R7 write range", cnt(4), 1);
        step(1, 0, 0, 0, 1, 14, 0, hold);
        step(1, 0, 0, 0, 0, 0, 1, 8'h77);
        check("R7 read range", cnt(4), 2);
        check("R7 counted not matched", int'(rd_total - match_total), 2);

        // R8: strobe without chip enable neither writes nor reads
        step(0, 1, 2, 8'hEE, 0, 0, 0, hold);
        check("R8 enable error", cnt(5), 1);
        step(1, 0, 0, 0, 1, 2, 0, hold);
        step(1, 0, 0, 0, 0, 0, 1, DW'(pat(2)));
        check("R8 no write", cnt(0), 1);

        // R9: saturation and stickiness
        for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 1, 0, 0, hold);
        check("R9 saturate", cnt(5), (1 << EW) - 1);
        check("R8 no read started", cnt(1), 2);
        repeat (3) step(1, 0, 0, 0, 0, 0, 0, hold);
        check("R9 sticky", int'(err_flags[5]), 1);

        // R9: reset clears
        live = 0;
        rst_n = 1'b0;
        step(0, 0, 0, 0, 0, 0, 0, hold);
        rst_n = 1'b1;
        live = 1;
        check("R9 reset clears counters", int'(err_counts), 0);
        check("R9 reset clears flags", int'(err_flags), 0);

        // legal mixed traffic with a bench-side memory
        foreach (fr[i]) fr[i] = 0;
        lf = 32'h1234_5678;
        pv = 0;
        pval = 0;
        for (int c = 0; c < 80; c++) begin
            bit dw, dr;
            int aw, ar, dv;
            logic [DW-1:0] nv;
            lf = lf * 1103515245 + 12345;
            dw = lf[13];
            dr = lf[17];
            aw = int'((lf >> 4) % DEPTH);
            ar = int'((lf >> 20) % DEPTH);
            if (dw && dr && aw == ar) ar = (ar + 1) % DEPTH;
            dv = int'(lf[31:24]);
            nv = DW'(fr[ar]);
            step(1, dw, aw, dv, dr, ar, pv, pv ? pval : hold);
            if (dw) fr[aw] = dv;
            pv = dr;
            pval = nv;
        end
        step(1, 0, 0, 0, 0, 0, pv, pv ? pval : hold);
        check("R2 random traffic clean", int'(err_counts), 0);
        check("R10 pass random", int'(pass), 1);

        live = 0;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule